// File: doc/BRIEF.md
# HD Serial Descrambler and Word Framer

This block sits right after an HD serial receiver. Each clock it takes one 20-bit parallel word. The word is normally still NRZI coded and scrambled, and its bit boundary is arbitrary. The block first undoes the NRZI coding (generator x+1). It then removes the self-synchronising scrambler (x^9+x^4+1). Both steps treat the 20 bits of a word least significant bit first, so bit 0 is the earliest bit on the wire.

The descrambled stream is then word framed. The framer looks for the timing-reference preamble, which in each 10-bit lane is 3FF, 000, 000 and then a status word. Across the 20-bit bus that is one all-ones word followed by two all-zeros words. When the framer finds the preamble it takes that bit offset and shifts every later word to it. The aligned word then carries luma in bits [19:10] and chroma in bits [9:0]. A one-cycle flag marks the output cycle that carries the status word.

The descrambler and the framer each have their own bypass input. A noise-immune option makes the framer keep its current offset until the preamble has been seen twice in a row at the same new offset.

Top module: `hd_deser_align`

## Requirements
- R1: With both bypasses low, a stream that was scrambled (x^9+x^4+1, registers starting at zero) and then NRZI coded leaves the block as the original clear data, word aligned.
- R2: With `dsc_bypass` high, the descrambler passes input bits unchanged, so clear input is framed and output unchanged.
- R3: With `frm_bypass` high, the output word is the descrambled input word with no bit shift. `trs_flag` then rises only for preambles that sit at bit offset 0.
- R4: With `noise_immune` low, every detected preamble sets the framing offset at once. The preamble's own first word already leaves aligned to the new offset.
- R5: With `noise_immune` high, a preamble at a new offset leaves the current offset unchanged. The offset moves only when the next preamble is found at that same new offset. A preamble at the current offset in between cancels the pending offset.
- R6: A word sampled at clock edge n appears on `dout` after edge n+4 (both bypasses high, no shift).
- R7: `trs_flag` is high for exactly the one cycle in which `dout` carries the status word, three words after the all-ones word. This holds only for preambles at the offset the output uses.
- R8: While `rst_n` is low, `dout` is all zeros, `trs_flag` is low, the offset is 0 and the descrambler state is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 20 | Raw received word, bit 0 earliest on the wire |
| dsc_bypass | input | 1 | High: skip NRZI decoding and descrambling |
| frm_bypass | input | 1 | High: no bit shift on output |
| noise_immune | input | 1 | High: move offset only on two consecutive matching preambles |
| dout | output | 20 | Aligned word: luma [19:10], chroma [9:0] |
| trs_flag | output | 1 | High in the cycle `dout` carries the preamble status word |

## Verification
Four-line streams with payload words kept in the legal range are encoded by a serial bit-level scrambler and NRZI coder in the bench. They are then shifted by a chosen bit offset, from 0 up to 19. The offset-0 runs separate descrambling faults from framing faults. The non-zero offsets show that the barrel shift takes bits from the correct neighbouring word.

The noise-immune runs use a shifted stream. The first line must leave the block unshifted and without a flag, and the later lines aligned. This separates immediate realignment from confirmed realignment. The bypass runs feed clear or shifted data to show that each bypass affects only its own stage. A single marked word measures the latency.

// File: rtl/hdfr_pkg.sv
package hdfr_pkg;
  localparam int WORD_W   = 20;            // two 10-bit lanes
  localparam int LANE_W   = WORD_W / 2;
  localparam int SCR_LEN  = 9;             // x^9 term
  localparam int SCR_TAP  = 4;             // x^4 term
  localparam int OFF_W    = $clog2(WORD_W);
  localparam int STAT_POS = 3;             // status word follows ones, zero, zero

  // x+1 NRZI decode: each bit XOR the bit before it on the wire
  function automatic logic [WORD_W-1:0] nrzi_decode(input logic [WORD_W-1:0] w,
                                                    input logic prev_bit);
    logic [WORD_W:0] ext;
    ext = {w, prev_bit};
    return ext[WORD_W:1] ^ ext[WORD_W-1:0];
  endfunction

  // self-synchronising descramble; hist holds the previous SCR_LEN bits,
  // hist[SCR_LEN-1] being the most recent
  function automatic logic [WORD_W-1:0] descramble(input logic [WORD_W-1:0] s,
                                                   input logic [SCR_LEN-1:0] hist);
    logic [WORD_W+SCR_LEN-1:0] ext;
    logic [WORD_W-1:0] r;
    ext = {s, hist};
    for (int i = 0; i < WORD_W; i++)
      r[i] = ext[SCR_LEN+i] ^ ext[SCR_LEN+i-SCR_TAP] ^ ext[i];
    return r;
  endfunction
endpackage

// File: rtl/hdfr_descrambler.sv
module hdfr_descrambler
  import hdfr_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  input  logic         bypass,
  output logic [W-1:0] dout
);
  logic               prev_raw_q;
  logic [SCR_LEN-1:0] hist_q;
  logic [W-1:0]       nrzi_w;
  logic [W-1:0]       clear_w;

  always_comb begin
    nrzi_w  = nrzi_decode(din, prev_raw_q);
    clear_w = descramble(nrzi_w, hist_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_raw_q <= 1'b0;
      hist_q     <= '0;
      dout       <= '0;
    end else begin
      prev_raw_q <= din[W-1];
      hist_q     <= nrzi_w[W-1 -: SCR_LEN];
      dout       <= bypass ? din : clear_w;
    end
  end
endmodule

// File: rtl/hdfr_trs_detect.sv
module hdfr_trs_detect
  import hdfr_pkg::*;
#(
  parameter int W = WORD_W,
  localparam int OW = $clog2(W)
) (
  input  logic [4*W-1:0] win,      // win[0] is the earliest bit
  output logic [W-1:0]   hit_vec,
  output logic           hit,
  output logic [OW-1:0]  hit_off
);
  localparam logic [3*W-1:0] PREAMBLE = {{(2*W){1'b0}}, {W{1'b1}}};

  for (genvar k = 0; k < W; k++) begin : g_off
    assign hit_vec[k] = (win[k +: 3*W] == PREAMBLE);
  end

  always_comb begin
    hit_off = '0;
    for (int k = W-1; k >= 0; k--)
      if (hit_vec[k]) hit_off = OW'(k);
  end
  assign hit = |hit_vec;

  // two offsets can never both match: ones would overlap zeros (R4)
  always_comb begin
    assert_single_match_R4: assert ($isunknown(hit_vec) || $onehot0(hit_vec));
  end
endmodule

// File: rtl/hdfr_framer.sv
module hdfr_framer
  import hdfr_pkg::*;
#(
  parameter int W = WORD_W,
  localparam int OW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] dsc_in,
  input  logic         bypass,
  input  logic         noise_immune,
  output logic [W-1:0] dout,
  output logic         trs_flag
);
  logic [W-1:0]    w1_q, w2_q, w3_q;
  logic [4*W-1:0]  window;
  logic [W-1:0]    hit_vec;
  logic            hit;
  logic [OW-1:0]   hit_off;
  logic [OW-1:0]   off_q, cand_q, eff_off, out_off;
  logic            cand_v_q;
  logic            is_new, confirm, commit, mark;
  logic [STAT_POS:0] lag_q;

  assign window = {dsc_in, w1_q, w2_q, w3_q};

  hdfr_trs_detect #(.W(W)) u_det (
    .win(window), .hit_vec(hit_vec), .hit(hit), .hit_off(hit_off)
  );

  always_comb begin
    is_new  = hit && (hit_off != off_q);
    confirm = cand_v_q && (cand_q == hit_off);
    commit  = is_new && (!noise_immune || confirm);
    eff_off = commit ? hit_off : off_q;
    out_off = bypass ? '0 : eff_off;
    mark    = hit && (hit_off == out_off);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w1_q <= '0; w2_q <= '0; w3_q <= '0;
      off_q <= '0; cand_q <= '0; cand_v_q <= 1'b0;
      dout <= '0;
    end else begin
      w1_q <= dsc_in; w2_q <= w1_q; w3_q <= w2_q;
      dout <= window[out_off +: W];
      if (commit) begin
        off_q    <= hit_off;
        cand_v_q <= 1'b0;
      end else if (is_new) begin
        cand_q   <= hit_off;
        cand_v_q <= 1'b1;
      end else if (hit) begin
        cand_v_q <= 1'b0;
      end
    end
  end

  // status word arrives STAT_POS words after the all-ones word
  for (genvar i = 0; i <= STAT_POS; i++) begin : g_lag
    always_ff @(posedge clk) begin
      if (!rst_n) lag_q[i] <= 1'b0;
      else        lag_q[i] <= (i == 0) ? mark : lag_q[(i == 0) ? 0 : i-1];
    end
  end
  assign trs_flag = lag_q[STAT_POS];

  assert_off_moves_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q != $past(off_q)) |-> $past(hit));

  assert_ni_needs_confirm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(noise_immune) && off_q != $past(off_q)) |-> ($past(cand_v_q) && off_q == $past(cand_q)));

  assert_flag_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trs_flag |=> !trs_flag);

  assert_offset_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    off_q < OW'(W));
endmodule

// File: rtl/hd_deser_align.sv
module hd_deser_align
  import hdfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] din,
  input  logic              dsc_bypass,
  input  logic              frm_bypass,
  input  logic              noise_immune,
  output logic [WORD_W-1:0] dout,
  output logic              trs_flag
);
  logic [WORD_W-1:0] dsc_w;

  hdfr_descrambler #(.W(WORD_W)) u_dsc (
    .clk(clk), .rst_n(rst_n), .din(din), .bypass(dsc_bypass), .dout(dsc_w)
  );

  hdfr_framer #(.W(WORD_W)) u_frm (
    .clk(clk), .rst_n(rst_n), .dsc_in(dsc_w), .bypass(frm_bypass),
    .noise_immune(noise_immune), .dout(dout), .trs_flag(trs_flag)
  );

  assert_reset_quiet_R8: assert property (@(posedge clk)
    !$past(rst_n) |-> (dout == '0 && !trs_flag));
endmodule

// File: tb/sim_hd_deser_align.sv
`timescale 1ns/1ps
module sim_hd_deser_align;
  localparam int NW  = 70;
  localparam int CBN = 20 * (NW + 2);
  localparam int LINE = 16;
  localparam int NLINES = 4;

  // scenario: {noise_immune, frm_bypass, dsc_bypass, offset[4:0]}
  localparam logic [7:0] SCEN [8] = '{
    {1'b0,1'b0,1'b0,5'd0},  {1'b0,1'b0,1'b0,5'd7},
    {1'b1,1'b0,1'b0,5'd13}, {1'b1,1'b0,1'b0,5'd0},
    {1'b0,1'b0,1'b1,5'd7},  {1'b0,1'b1,1'b0,5'd11},
    {1'b0,1'b1,1'b0,5'd0},  {1'b0,1'b0,1'b0,5'd19}
  };

  logic clk = 0, rst_n = 0;
  logic [19:0] din = '0;
  logic dsc_bypass = 0, frm_bypass = 0, noise_immune = 0;
  logic [19:0] dout;
  logic trs_flag;
  int n_chk = 0, n_bad = 0, cyc = 0;
  logic cb [CBN];
  logic sb [CBN];
  logic tx [CBN];

  always #2 clk = ~clk;

  hd_deser_align u0 (.clk(clk), .rst_n(rst_n), .din(din), .dsc_bypass(dsc_bypass),
    .frm_bypass(frm_bypass), .noise_immune(noise_immune), .dout(dout), .trs_flag(trs_flag));

  task automatic chk(input logic ok, input string req, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %05h expected %05h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] clear_word(input int w);
    int ln, p;
    ln = w / LINE; p = w % LINE;
    if (w < LINE*NLINES && p == 0) return 20'hFFFFF;
    if (w < LINE*NLINES && (p == 1 || p == 2)) return 20'h0;
    if (w < LINE*NLINES && p == 3) return {10'(10'h280 + 4*ln), 10'(10'h2C0 + 4*ln)};
    return {10'(10'h040 + (w*37) % 10'h300), 10'(10'h100 + (w*11) % 10'h200)};
  endfunction

  function automatic logic [19:0] chunk(input int i);
    logic [19:0] r;
    for (int b = 0; b < 20; b++) r[b] = cb[20*i+b];
    return r;
  endfunction

  function automatic logic [19:0] fed(input int i);
    logic [19:0] r;
    for (int b = 0; b < 20; b++) r[b] = tx[20*i+b];
    return r;
  endfunction

  task automatic build(input int k, input logic scr);
    logic [19:0] cw;
    for (int n = 0; n < CBN; n++) cb[n] = 1'b0;
    for (int w = 0; w < NW; w++) begin
      cw = clear_word(w);
      for (int b = 0; b < 20; b++) cb[k+20*w+b] = cw[b];
    end
    for (int n = 0; n < CBN; n++) begin
      sb[n] = cb[n] ^ (n >= 4 ? sb[n-4] : 1'b0) ^ (n >= 9 ? sb[n-9] : 1'b0);
      tx[n] = scr ? (sb[n] ^ (n > 0 ? tx[n-1] : 1'b0)) : cb[n];
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; din = '0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    do_reset();
    chk(dout == 20'h0, "R8 reset dout", dout, 20'h0);
    chk(trs_flag == 1'b0, "R8 reset flag", {19'h0, trs_flag}, 20'h0);

    foreach (SCEN[s]) begin
      automatic int k = int'(SCEN[s][4:0]);
      automatic logic bpd = SCEN[s][5];
      automatic logic bpf = SCEN[s][6];
      automatic logic ni = SCEN[s][7];
      automatic int commit_idx = (ni && k != 0 && !bpf) ? LINE : 0;
      automatic string tag = bpf ? "R3" : (bpd ? "R2" : (ni ? "R5" : (k != 0 ? "R4" : "R1")));
      build(k, !bpd);
      dsc_bypass = bpd; frm_bypass = bpf; noise_immune = ni;
      do_reset();
      for (int c = 0; c < NW + 6; c++) begin
        @(negedge clk);
        if (c >= 5 && c - 5 < NW) begin
          automatic int i = c - 5;
          automatic logic [19:0] e = (bpf || i < commit_idx) ? chunk(i) : clear_word(i);
          automatic int ln = i / LINE;
          automatic logic lmark = bpf ? (k == 0) : (ni && k != 0 ? ln >= 1 : 1'b1);
          automatic logic ef = (i < LINE*NLINES) && (i % LINE == STAT) && lmark;
          chk(dout == e, tag, dout, e);
          chk(trs_flag == ef, "R7 flag", {19'h0, trs_flag}, {19'h0, ef});
        end
        din = (c <= NW) ? fed(c) : 20'h0;
      end
    end

    // R6: latency of exactly four edges with both bypasses
    dsc_bypass = 1; frm_bypass = 1; noise_immune = 0;
    do_reset();
    @(negedge clk); din = 20'h5A3C6;
    @(negedge clk); din = 20'h0;
    repeat (3) @(negedge clk);
    chk(dout == 20'h0, "R6 early", dout, 20'h0);
    @(negedge clk);
    chk(dout == 20'h5A3C6, "R6 latency", dout, 20'h5A3C6);

    // R8: reset mid-stream clears the output
    @(negedge clk); din = 20'h12345; rst_n = 0;
    @(negedge clk);
    chk(dout == 20'h0, "R8 mid reset", dout, 20'h0);
    rst_n = 1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  localparam int STAT = 3;
endmodule